// File: doc/BRIEF.md
# Entry-Relative Exit Predictor

This block predicts, one step at a time, which extended basic block (a straight run of code with one entry and one predicted way out) a processor front end will run next. It holds the entry address of the block being predicted, looks that address up in a direct-mapped prediction table, and produces the predicted next entry address together with a transfer-kind code. The table stores targets as signed offsets from the current entry rather than as full addresses. One reserved offset value marks a return, whose target comes from a small return-address stack instead. Calls push their continuation address onto that stack.

Each prediction becomes the new current entry, so the block walks a chain of predictions ahead of fetch. A lookahead counter caps how far the chain may run beyond what fetch has consumed. When the back end detects a wrong path it signals a correction with the right entry address. The chain is then flushed and restarted from that address after a fixed stall. Table contents are written through a single update port.

Top module: `ebb_exit_predictor`

## Requirements
- R1: After reset `pred_valid`, `stall`, `no_pred` and `ret_err` are low, no chain is active, every table slot is invalid so that any lookup misses, and the return stack is empty.
- R2: The table slot is the XOR of all 6-bit chunks of the entry address (bits 5:0, 11:6, 15:12 zero-padded). The stored tag is address bits 11:6. A lookup hits only on a valid slot with a matching tag. A miss on an eligible cycle raises `no_pred` for one cycle and holds the chain in place.
- R3: On a hit with an ordinary offset, the next entry is the current entry plus the sign-extended 10-bit offset, and it becomes the new current entry. Offset 0 (a block that loops to itself) is valid. `pred_kind` reports the stored kind: 0 jump, 1 call, 2 return, 3 leave.
- R4: An entry of kind 1 pushes the current entry plus the zero-extended 8-bit link field onto the return stack. The offset value 10'h200 (most negative) means return: the next entry is popped from the stack.
- R5: A correction loads the current entry from `corr_addr`, clears the outstanding count, suppresses output in that cycle and restarts the chain. It also restarts a chain halted by a return-stack underflow.
- R6: `stall` is high for exactly 5 cycles after the edge that takes a correction, and no prediction is issued while it is high.
- R7: At most 4 predictions may be outstanding. Each `fetch_ack` cycle releases one, and a full counter blocks further predictions.
- R8: The return stack holds 8 addresses, and a ninth push drops the oldest. A return with an empty stack pulses `ret_err` and issues no prediction. The chain then halts until the next correction.
- R9: An update write replaces the slot its address maps to, and lookups see it from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| corr_valid | input | 1 | Correction: restart the chain at `corr_addr` |
| corr_addr | input | 16 | Corrected entry address |
| fetch_ack | input | 1 | Fetch consumed one outstanding prediction |
| upd_valid | input | 1 | Table write strobe |
| upd_addr | input | 16 | Entry address whose slot is written |
| upd_offset | input | 10 | Signed target offset, 10'h200 marks return |
| upd_link | input | 8 | Continuation distance pushed by calls |
| upd_kind | input | 2 | Transfer kind (0 jump, 1 call, 2 return, 3 leave) |
| pred_valid | output | 1 | One-cycle pulse per issued prediction |
| pred_next | output | 16 | Predicted next entry address |
| pred_kind | output | 2 | Kind of the transfer that was predicted |
| no_pred | output | 1 | Lookup of the current entry missed |
| ret_err | output | 1 | Return found the stack empty |
| stall | output | 1 | Correction penalty in progress |

## Verification
Each prediction is registered, so `pred_valid`, `pred_next` and `pred_kind` appear one edge after the lookup that made them. After a correction taken on edge P0, `stall` reads high for the five cycles following P0. The first prediction is then due after edge P6. `no_pred` and `ret_err` follow their lookup by one edge, and a table write is visible to the lookup one edge after it is taken. The bench drives inputs and samples outputs on falling edges and records every pulse in a window. Sequences and stall lengths are therefore compared against these latencies without racing the rising edge.

// File: rtl/ebp_pkg.sv
package ebp_pkg;
  typedef enum logic [1:0] {
    KIND_JUMP  = 2'd0,
    KIND_CALL  = 2'd1,
    KIND_RET   = 2'd2,
    KIND_LEAVE = 2'd3
  } xfer_kind_t;
endpackage

// File: rtl/ebp_table.sv
module ebp_table #(
  parameter int AW = 16,
  parameter int OW = 10,
  parameter int LW = 8,
  parameter int IW = 6,
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [OW-1:0] wr_ofs,
  input  logic [LW-1:0] wr_link,
  input  logic [1:0]    wr_kind,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_hit,
  output logic [OW-1:0] rd_ofs,
  output logic [LW-1:0] rd_link,
  output logic [1:0]    rd_kind
);
  localparam int SLOTS = 1 << IW;
  localparam int NCH   = (AW + IW - 1) / IW;
  localparam int PADW  = NCH * IW;

  function automatic logic [IW-1:0] slot_of(input logic [AW-1:0] a);
    logic [PADW-1:0] p;
    logic [IW-1:0]   s;
    p = '0;
    p[AW-1:0] = a;
    s = '0;
    for (int i = 0; i < NCH; i++) s = s ^ p[i*IW +: IW];
    return s;
  endfunction

  function automatic logic [TW-1:0] tag_of(input logic [AW-1:0] a);
    return a[IW +: TW];
  endfunction

  logic [SLOTS-1:0] valid_q;
  logic [TW-1:0]    tag_mem  [SLOTS];
  logic [OW-1:0]    ofs_mem  [SLOTS];
  logic [LW-1:0]    link_mem [SLOTS];
  logic [1:0]       kind_mem [SLOTS];

  logic [IW-1:0] wr_slot, rd_slot;
  assign wr_slot = slot_of(wr_addr);
  assign rd_slot = slot_of(rd_addr);

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (wr_en) valid_q[wr_slot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_slot]  <= tag_of(wr_addr);
      ofs_mem[wr_slot]  <= wr_ofs;
      link_mem[wr_slot] <= wr_link;
      kind_mem[wr_slot] <= wr_kind;
    end
  end

  always_comb begin
    rd_hit  = valid_q[rd_slot] && (tag_mem[rd_slot] == tag_of(rd_addr));
    rd_ofs  = ofs_mem[rd_slot];
    rd_link = link_mem[rd_slot];
    rd_kind = kind_mem[rd_slot];
  end

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && !$past(rst) && rd_addr == $past(wr_addr)) |-> rd_hit); // R9
endmodule

// File: rtl/ebp_ret_stack.sv
module ebp_ret_stack #(
  parameter int AW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          pop,
  output logic [AW-1:0] top_addr,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] tp;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction
  function automatic logic [PW-1:0] prv(input logic [PW-1:0] p);
    return (p == '0) ? LAST : p - 1'b1;
  endfunction

  assign tp       = prv(wp_q);
  assign top_addr = mem[tp];
  assign empty    = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= push_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      cnt_q <= '0;
    end else if (push) begin
      wp_q <= nxt(wp_q);
      if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end else if (pop) begin
      wp_q  <= tp;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_DEPTH_BOUND:  assert property (@(posedge clk) disable iff (rst) cnt_q <= FULL); // R8
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst) pop |-> !empty); // R8
  AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (rst) !(push && pop)); // R4
endmodule

// File: rtl/ebp_stall_timer.sv
module ebp_stall_timer #(
  parameter int CYCLES = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  AST_STALL_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
    (busy && !load) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R6
endmodule

// File: rtl/ebb_exit_predictor.sv
module ebb_exit_predictor #(
  parameter int AW           = 16,
  parameter int OW           = 10,
  parameter int LW           = 8,
  parameter int IW           = 6,
  parameter int TW           = 6,
  parameter int RS_DEPTH     = 8,
  parameter int AHEAD        = 4,
  parameter int STALL_CYCLES = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          corr_valid,
  input  logic [AW-1:0] corr_addr,
  input  logic          fetch_ack,
  input  logic          upd_valid,
  input  logic [AW-1:0] upd_addr,
  input  logic [OW-1:0] upd_offset,
  input  logic [LW-1:0] upd_link,
  input  logic [1:0]    upd_kind,
  output logic          pred_valid,
  output logic [AW-1:0] pred_next,
  output logic [1:0]    pred_kind,
  output logic          no_pred,
  output logic          ret_err,
  output logic          stall
);
  import ebp_pkg::*;

  localparam int CW = $clog2(AHEAD + 1);
  localparam logic [CW-1:0] AHEAD_C  = CW'(AHEAD);
  localparam logic [OW-1:0] RET_MARK = {1'b1, {(OW-1){1'b0}}};

  logic [AW-1:0] cur_q;
  logic          live_q;
  logic [CW-1:0] out_q;

  logic          tb_hit;
  logic [OW-1:0] tb_ofs;
  logic [LW-1:0] tb_link;
  logic [1:0]    tb_kind;
  logic [AW-1:0] rs_top;
  logic          rs_empty;
  logic          stall_busy;

  logic          is_ret, can_step, uflow, step, rs_push, rs_pop, ack_dec;
  logic [AW-1:0] next_addr, link_addr, ofs_ext;

  ebp_table #(.AW(AW), .OW(OW), .LW(LW), .IW(IW), .TW(TW)) table_i (
    .clk(clk), .rst(rst),
    .wr_en(upd_valid), .wr_addr(upd_addr), .wr_ofs(upd_offset),
    .wr_link(upd_link), .wr_kind(upd_kind),
    .rd_addr(cur_q), .rd_hit(tb_hit), .rd_ofs(tb_ofs),
    .rd_link(tb_link), .rd_kind(tb_kind)
  );

  ebp_ret_stack #(.AW(AW), .DEPTH(RS_DEPTH)) stack_i (
    .clk(clk), .rst(rst),
    .push(rs_push), .push_addr(link_addr), .pop(rs_pop),
    .top_addr(rs_top), .empty(rs_empty)
  );

  ebp_stall_timer #(.CYCLES(STALL_CYCLES)) timer_i (
    .clk(clk), .rst(rst), .load(corr_valid), .busy(stall_busy)
  );

  always_comb begin
    ofs_ext   = {{(AW-OW){tb_ofs[OW-1]}}, tb_ofs};
    link_addr = cur_q + {{(AW-LW){1'b0}}, tb_link};
    is_ret    = tb_hit && (tb_ofs == RET_MARK);
    can_step  = live_q && !stall_busy && (out_q < AHEAD_C) && !corr_valid;
    uflow     = can_step && is_ret && rs_empty;
    step      = can_step && tb_hit && !uflow;
    next_addr = is_ret ? rs_top : cur_q + ofs_ext;
    rs_push   = step && !is_ret && (xfer_kind_t'(tb_kind) == KIND_CALL);
    rs_pop    = step && is_ret;
    ack_dec   = fetch_ack && (out_q != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q      <= '0;
      live_q     <= 1'b0;
      out_q      <= '0;
      pred_valid <= 1'b0;
      pred_next  <= '0;
      pred_kind  <= '0;
      no_pred    <= 1'b0;
      ret_err    <= 1'b0;
    end else if (corr_valid) begin
      cur_q      <= corr_addr;
      live_q     <= 1'b1;
      out_q      <= '0;
      pred_valid <= 1'b0;
      no_pred    <= 1'b0;
      ret_err    <= 1'b0;
    end else begin
      pred_valid <= step;
      if (step) begin
        cur_q     <= next_addr;
        pred_next <= next_addr;
        pred_kind <= tb_kind;
      end
      out_q   <= out_q + CW'(step) - CW'(ack_dec);
      no_pred <= can_step && !tb_hit;
      ret_err <= uflow;
      if (uflow) live_q <= 1'b0;
    end
  end

  assign stall = stall_busy;

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    stall |=> !pred_valid); // R6
  AST_AHEAD_CAP: assert property (@(posedge clk) disable iff (rst)
    out_q <= AHEAD_C); // R7
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (out_q == AHEAD_C) |=> !pred_valid); // R7
  AST_CORR_FLUSH: assert property (@(posedge clk) disable iff (rst)
    corr_valid |=> (out_q == '0 && !pred_valid)); // R5
  AST_UFLOW_NO_PRED: assert property (@(posedge clk) disable iff (rst)
    ret_err |-> !pred_valid); // R8
endmodule

// File: tb/ebb_exit_predictor_tb.sv
module ebb_exit_predictor_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        corr_valid = 1'b0;
  logic [15:0] corr_addr = '0;
  logic        fetch_ack = 1'b0;
  logic        upd_valid = 1'b0;
  logic [15:0] upd_addr = '0;
  logic [9:0]  upd_offset = '0;
  logic [7:0]  upd_link = '0;
  logic [1:0]  upd_kind = '0;
  logic        pred_valid;
  logic [15:0] pred_next;
  logic [1:0]  pred_kind;
  logic        no_pred, ret_err, stall;

  ebb_exit_predictor dut_i (
    .clk(clk), .rst(rst), .corr_valid(corr_valid), .corr_addr(corr_addr),
    .fetch_ack(fetch_ack), .upd_valid(upd_valid), .upd_addr(upd_addr),
    .upd_offset(upd_offset), .upd_link(upd_link), .upd_kind(upd_kind),
    .pred_valid(pred_valid), .pred_next(pred_next), .pred_kind(pred_kind),
    .no_pred(no_pred), .ret_err(ret_err), .stall(stall)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {addr16, offset10, link8, kind2, expected next16, expected kind2}
  localparam logic [53:0] VEC [4] = '{
    {16'h0100, 10'h100, 8'h40, 2'd1, 16'h0200, 2'd1},
    {16'h0200, 10'h380, 8'h00, 2'd0, 16'h0180, 2'd0},
    {16'h0180, 10'h200, 8'h00, 2'd2, 16'h0140, 2'd2},
    {16'h0140, 10'h000, 8'h00, 2'd0, 16'h0140, 2'd0}
  };

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [15:0] got_a [32];
  logic [1:0]  got_k [32];
  int n_got, n_err, n_nopred, n_stall;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_entry(input logic [15:0] a, input logic [9:0] o,
                             input logic [7:0] l, input logic [1:0] k);
    @(negedge clk);
    upd_valid = 1'b1; upd_addr = a; upd_offset = o; upd_link = l; upd_kind = k;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic correct(input logic [15:0] a);
    @(negedge clk);
    corr_valid = 1'b1; corr_addr = a;
    @(negedge clk);
    corr_valid = 1'b0;
  endtask

  // samples the current falling edge first, then advances
  task automatic collect(input int ncyc, input logic ack);
    n_got = 0; n_err = 0; n_nopred = 0; n_stall = 0;
    fetch_ack = ack;
    for (int i = 0; i < ncyc; i++) begin
      if (pred_valid && n_got < 32) begin
        got_a[n_got] = pred_next;
        got_k[n_got] = pred_kind;
        n_got++;
      end
      if (ret_err) n_err++;
      if (no_pred) n_nopred++;
      if (stall)   n_stall++;
      @(negedge clk);
    end
    fetch_ack = 1'b0;
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    checks++;
    $display("FAIL watchdog all-requirements actual=%0d expected=<100000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(pred_valid == 1'b0, "R1 pred_valid", pred_valid, 0);
    check(stall == 1'b0,      "R1 stall", stall, 0);
    check(no_pred == 1'b0,    "R1 no_pred", no_pred, 0);
    check(ret_err == 1'b0,    "R1 ret_err", ret_err, 0);
    correct(16'h0100);
    collect(12, 1'b1);
    check(n_got == 0,   "R1 empty table gives no prediction", n_got, 0);
    check(n_nopred > 0, "R1 empty table misses", n_nopred, 1);

    // main vector walk: R3, R4 call/return, R6 stall length
    for (int i = 0; i < 4; i++)
      write_entry(VEC[i][53:38], VEC[i][37:28], VEC[i][27:20], VEC[i][19:18]);
    correct(VEC[0][53:38]);
    collect(14, 1'b1);
    check(n_stall == 5, "R6 stall length", n_stall, 5);
    check(n_got >= 5,   "R3 chain length", n_got, 5);
    for (int i = 0; i < 4; i++) begin
      check(got_a[i] == VEC[i][17:2], "R3/R4 next entry", got_a[i], VEC[i][17:2]);
      check(got_k[i] == VEC[i][1:0],  "R3 kind", got_k[i], VEC[i][1:0]);
    end
    check(got_a[4] == 16'h0140, "R3 self-loop offset zero", got_a[4], 16'h0140);

    // R7 lookahead cap
    correct(16'h0140);
    collect(20, 1'b0);
    check(n_got == 4, "R7 outstanding cap", n_got, 4);
    collect(1, 1'b1);
    collect(10, 1'b0);
    check(n_got == 1, "R7 one ack releases one", n_got, 1);

    // R8 underflow on empty stack, R5 restart from halted chain
    correct(16'h0180);
    collect(15, 1'b1);
    check(n_err == 1, "R8 underflow flag", n_err, 1);
    check(n_got == 0, "R8 no prediction on underflow", n_got, 0);

    // R2 tag mismatch (0x0004 shares slot 4 with 0x0100), R9 write then hit
    correct(16'h0004);
    collect(12, 1'b1);
    check(n_got == 0,   "R2 tag mismatch gives no prediction", n_got, 0);
    check(n_nopred > 0, "R2 tag mismatch raises no_pred", n_nopred, 1);
    write_entry(16'h0004, 10'h010, 8'h00, 2'd0);
    collect(6, 1'b1);
    check(n_got == 1, "R9 written entry predicts", n_got, 1);
    check(got_a[0] == 16'h0014, "R9 written target", got_a[0], 16'h0014);
    check(n_nopred > 0, "R2 next entry misses", n_nopred, 1);

    // R8 overflow drops oldest: nine calls then returns
    for (int k = 0; k < 10; k++)
      write_entry(16'h0800 + 16'(k*64), (k < 9) ? 10'h040 : 10'h200, 8'h20,
                  (k < 9) ? 2'd1 : 2'd2);
    for (int k = 0; k < 9; k++)
      write_entry(16'h0820 + 16'(k*64), 10'h200, 8'h00, 2'd2);
    correct(16'h0800);
    collect(40, 1'b1);
    check(n_got == 17, "R8 overflow chain length", n_got, 17);
    for (int k = 0; k < 9; k++)
      check(got_a[k] == 16'h0840 + 16'(k*64) && got_k[k] == 2'd1,
            "R4 call chain", got_a[k], 16'h0840 + 16'(k*64));
    for (int j = 0; j < 8; j++)
      check(got_a[9+j] == 16'h0820 + 16'((8-j)*64) && got_k[9+j] == 2'd2,
            "R8 pop order after overflow", got_a[9+j], 16'h0820 + 16'((8-j)*64));
    check(n_err == 1, "R8 oldest dropped then underflow", n_err, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule